// File: doc/BRIEF.md
# LCD Blink Window Controller

This block sits beside an LCD phase sequencer and decides, frame by frame, which picture the sequencer should drive: the normal segment data, the alternate segment data, or a blank screen. When blinking is off, it passes on the display mode that is configured. When blinking is on, a counter on the LCD clock divides time into two half-periods of equal length. The first half shows the configured display and the second half shows the blink picture, and the two then alternate. A 3-bit rate code picks the length of the period in powers of two.

The blink picture depends on a mode input. Mode 0 blanks the glass. Mode 1 shows the alternate plane, but only when the duty code says that fewer than five backplanes are in use. With five or more backplanes, mode 1 falls back to blank. The rate code is sampled only at blink toggles. Both outputs change only on the clock edge that follows a frame-boundary strobe from the sequencer, so the sequencer never shows a partial frame.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: After synchronous reset, `disp_sel` is 0 (normal) and `blink_phase` is 0.
- R2: While `blink_en` is 0, `disp_sel` follows `base_mode` and `blink_phase` is 0. The codes are 0 normal, 1 alternate and 2 blank; base code 3 is treated as blank.
- R3: The blink counter holds zero while `blink_en` is 0. After `blink_en` is first sampled high, the internal blink state stays low for 2^(BASE_LOG2-1+n) clock cycles, so the first half-period shows the configured display.
- R4: A rate code n of 0 to 7 gives a full blink period of 2^(BASE_LOG2+n) clock cycles, split into two equal halves.
- R5: During the blink half-period with `blink_mode`=0, `disp_sel` is 2 (blank) and `blink_phase` is 1.
- R6: During the blink half-period with `blink_mode`=1 and `duty_code` below 4 (duty code d means d+1 backplanes), `disp_sel` is 1 (alternate).
- R7: During the blink half-period with `blink_mode`=1 and `duty_code` of 4 or more, `disp_sel` is 2 (blank).
- R8: When `blink_en` is cleared, the next frame boundary brings `blink_phase` back to 0 and `disp_sel` back to the configured mode.
- R9: The rate code is sampled when blinking is enabled and again at each blink toggle. A change made during a half-period only sets the length of the half-period that follows the next toggle.
- R10: `disp_sel` and `blink_phase` change only on the clock edge after a cycle in which `frame_tick` is 1. In all other cycles they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock |
| rst | input | 1 | Synchronous active-high reset |
| blink_en | input | 1 | Blink enable |
| blink_mode | input | 1 | Blink picture: 0 blank, 1 alternate |
| rate_sel | input | 3 | Blink rate code n |
| duty_code | input | 3 | Backplanes in use minus one |
| base_mode | input | 2 | Configured display mode code |
| frame_tick | input | 1 | Frame-boundary strobe from the sequencer |
| disp_sel | output | 2 | Display select to the sequencer |
| blink_phase | output | 1 | 1 during the blink half-period |

## Verification
The internal blink state toggles on the edge at which the counter holds its last value, which is 2^(BASE_LOG2-1+n) edges after enable. The outputs register that change one edge later, and only if `frame_tick` was high. With `frame_tick` held high, the bench therefore expects the outputs unchanged after exactly that many edges and updated after one more edge. It samples at the falling edge in both places, so that a one-cycle error in either direction is caught. In the frame-alignment and disable tests, the bench expects each result one edge after the strobe or the cleared enable.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;

    typedef enum logic [1:0] {
        SEL_NORMAL = 2'd0,
        SEL_ALT    = 2'd1,
        SEL_BLANK  = 2'd2
    } disp_sel_e;

    typedef struct packed {
        logic      phase;
        disp_sel_e sel;
    } blink_out_t;

    // Map the configured display mode code onto a legal select.
    function automatic disp_sel_e map_base(input logic [1:0] code);
        case (code)
            2'd0:    return SEL_NORMAL;
            2'd1:    return SEL_ALT;
            default: return SEL_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/lcd_blink_timer.sv
module lcd_blink_timer #(
    parameter int BASE_LOG2 = 12,
    parameter int RATE_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              state
);
    localparam int CW = BASE_LOG2 + (1 << RATE_W) - 1;

    logic [CW-1:0]     cnt;
    logic [RATE_W-1:0] rate_q;
    logic [CW-1:0]     last;
    int                shamt;

    always_comb begin
        shamt = BASE_LOG2 - 1 + int'(rate_q);
        last  = (CW'(1) << shamt) - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt    <= '0;
            state  <= 1'b0;
            rate_q <= rate_sel;
        end else if (cnt == last) begin
            cnt    <= '0;
            state  <= ~state;
            rate_q <= rate_sel;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/lcd_blink_select.sv
module lcd_blink_select
    import lcd_blink_pkg::*;
#(
    parameter int DUTY_W     = 3,
    parameter int ALT_MAX_BP = 4
) (
    input  logic              active,
    input  logic              blink_mode,
    input  logic [DUTY_W-1:0] duty_code,
    input  logic [1:0]        base_mode,
    output blink_out_t        nxt
);
    localparam int ALT_LIMIT = ALT_MAX_BP - 1;

    logic alt_ok;

    always_comb begin
        alt_ok    = (int'(duty_code) <= ALT_LIMIT);
        nxt.phase = active;
        if (!active)
            nxt.sel = map_base(base_mode);
        else if (blink_mode && alt_ok)
            nxt.sel = SEL_ALT;
        else
            nxt.sel = SEL_BLANK;
    end
endmodule

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl
    import lcd_blink_pkg::*;
#(
    parameter int BASE_LOG2  = 12,
    parameter int RATE_W     = 3,
    parameter int DUTY_W     = 3,
    parameter int ALT_MAX_BP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blink_en,
    input  logic              blink_mode,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [DUTY_W-1:0] duty_code,
    input  logic [1:0]        base_mode,
    input  logic              frame_tick,
    output logic [1:0]        disp_sel,
    output logic              blink_phase
);
    logic       raw_state;
    blink_out_t nxt;
    blink_out_t cur;

    lcd_blink_timer #(
        .BASE_LOG2 (BASE_LOG2),
        .RATE_W    (RATE_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .enable   (blink_en),
        .rate_sel (rate_sel),
        .state    (raw_state)
    );

    lcd_blink_select #(
        .DUTY_W     (DUTY_W),
        .ALT_MAX_BP (ALT_MAX_BP)
    ) u_sel (
        .active     (raw_state & blink_en),
        .blink_mode (blink_mode),
        .duty_code  (duty_code),
        .base_mode  (base_mode),
        .nxt        (nxt)
    );

    // Outputs move only at a frame boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur.phase <= 1'b0;
            cur.sel   <= SEL_NORMAL;
        end else if (frame_tick) begin
            cur <= nxt;
        end
    end

    assign disp_sel    = cur.sel;
    assign blink_phase = cur.phase;
endmodule

// File: rtl/lcd_blink_chk.sv
module lcd_blink_chk #(
    parameter int DUTY_W     = 3,
    parameter int ALT_MAX_BP = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              blink_en,
    input logic              blink_mode,
    input logic [DUTY_W-1:0] duty_code,
    input logic              frame_tick,
    input logic [1:0]        disp_sel,
    input logic              blink_phase
);
    p_legal_sel_r2: assert property (@(posedge clk) disable iff (rst)
        disp_sel != 2'd3);

    p_frame_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> ($stable(disp_sel) && $stable(blink_phase)));

    p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !blink_en) |=> !blink_phase);

    p_mode0_blank_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !blink_mode) |=> (!blink_phase || disp_sel == 2'd2));

    p_many_bp_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && int'(duty_code) >= ALT_MAX_BP) |=> (!blink_phase || disp_sel == 2'd2));

    p_blink_not_normal_r6: assert property (@(posedge clk) disable iff (rst)
        blink_phase |-> disp_sel != 2'd0);
endmodule

bind lcd_blink_ctrl lcd_blink_chk #(
    .DUTY_W     (DUTY_W),
    .ALT_MAX_BP (ALT_MAX_BP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .blink_en    (blink_en),
    .blink_mode  (blink_mode),
    .duty_code   (duty_code),
    .frame_tick  (frame_tick),
    .disp_sel    (disp_sel),
    .blink_phase (blink_phase)
);

// File: tb/lcd_blink_ctrl_tb_top.sv
module lcd_blink_ctrl_tb_top;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       blink_en;
    logic       blink_mode;
    logic [2:0] rate_sel;
    logic [2:0] duty_code;
    logic [1:0] base_mode;
    logic       frame_tick;
    logic [1:0] disp_sel;
    logic       blink_phase;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lcd_blink_ctrl #(.BASE_LOG2(BASE)) dut_i (
        .clk(clk), .rst(rst), .blink_en(blink_en), .blink_mode(blink_mode),
        .rate_sel(rate_sel), .duty_code(duty_code), .base_mode(base_mode),
        .frame_tick(frame_tick), .disp_sel(disp_sel), .blink_phase(blink_phase)
    );

    // {mode, duty[2:0], base[1:0], expected blink select[1:0]}
    localparam logic [7:0] VEC [8] = '{
        {1'b0, 3'd0, 2'd0, 2'd2},
        {1'b1, 3'd0, 2'd0, 2'd1},
        {1'b1, 3'd3, 2'd0, 2'd1},
        {1'b1, 3'd4, 2'd0, 2'd2},
        {1'b1, 3'd7, 2'd1, 2'd2},
        {1'b0, 3'd2, 2'd1, 2'd2},
        {1'b1, 3'd1, 2'd2, 2'd1},
        {1'b0, 3'd3, 2'd3, 2'd2}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] exp_sel, input logic exp_ph);
        n_run++;
        if (disp_sel !== exp_sel || blink_phase !== exp_ph) begin
            n_fail++;
            $display("FAIL %s: sel=%0d phase=%0d expected sel=%0d phase=%0d",
                     req, disp_sel, blink_phase, exp_sel, exp_ph);
        end
    endtask

    function automatic logic [1:0] base_exp(input logic [1:0] b);
        return (b == 2'd3) ? 2'd2 : b;
    endfunction

    initial begin
        rst = 1'b1; blink_en = 1'b0; blink_mode = 1'b0; rate_sel = 3'd0;
        duty_code = 3'd0; base_mode = 2'd1; frame_tick = 1'b1;
        step(3);
        chk("R1", 2'd0, 1'b0);
        rst = 1'b0;
        step(1);
        chk("R2", 2'd1, 1'b0);

        // Table walk: each vector through one full blink period at rate 0.
        for (int i = 0; i < 8; i++) begin
            blink_en = 1'b0;
            {blink_mode, duty_code, base_mode} = VEC[i][7:2];
            step(2);
            chk("R2", base_exp(base_mode), 1'b0);
            blink_en = 1'b1;
            step(8);
            chk("R3", base_exp(base_mode), 1'b0);
            step(1);
            chk(blink_mode ? (duty_code >= 3'd4 ? "R7" : "R6") : "R5", VEC[i][1:0], 1'b1);
            step(8);
            chk("R4", base_exp(base_mode), 1'b0);
        end

        // Rate codes: first toggle after 2^(BASE-1+n) edges; then disable.
        blink_mode = 1'b0; base_mode = 2'd0; duty_code = 3'd0;
        for (int n = 0; n < 4; n++) begin
            blink_en = 1'b0;
            rate_sel = 3'(n);
            step(2);
            blink_en = 1'b1;
            step(1 << (BASE - 1 + n));
            chk("R4", 2'd0, 1'b0);
            step(1);
            chk("R4", 2'd2, 1'b1);
            blink_en = 1'b0;
            step(1);
            chk("R8", 2'd0, 1'b0);
        end

        // Rate change mid half-period applies after the next toggle.
        rate_sel = 3'd0;
        step(1);
        blink_en = 1'b1;
        step(3);
        rate_sel = 3'd2;
        step(5);
        chk("R9", 2'd0, 1'b0);
        step(1);
        chk("R9", 2'd2, 1'b1);
        step(31);
        chk("R9", 2'd2, 1'b1);
        step(1);
        chk("R9", 2'd0, 1'b0);

        // Frame alignment: no strobe, no change.
        blink_en = 1'b0; rate_sel = 3'd0;
        step(2);
        frame_tick = 1'b0;
        blink_en = 1'b1;
        step(12);
        chk("R10", 2'd0, 1'b0);
        frame_tick = 1'b1;
        step(1);
        chk("R10", 2'd2, 1'b1);
        frame_tick = 1'b0;
        blink_en = 1'b0;
        base_mode = 2'd1;
        step(3);
        chk("R10", 2'd2, 1'b1);
        frame_tick = 1'b1;
        step(1);
        chk("R8", 2'd1, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule